// File: doc/BRIEF.md
# Vehicle Alarm Sequencing Controller

This block is the sequencing core of a car alarm. It watches debounced ignition, driver-door, passenger-door, hidden-switch and brake levels. It drives a status lamp, a siren enable and a fuel-pump enable. It does not count seconds itself. It asks an external countdown timer for one of four intervals by placing a 2-bit interval code on `tmr_sel` and pulsing `tmr_start`. It then acts on the timer's `tmr_expired` level. A one-second tick input paces the lamp blink. A reprogram strobe, raised whenever the timer's interval table is rewritten, throws the sequence back to the armed state.

The controller arms itself once the driver has switched off, left the car and shut every door, and a settling interval has then passed. When armed, it starts a countdown whose length depends on which door opened first. It sounds the siren if the ignition is not switched on before the countdown ends. It silences the siren only after every door has been shut for a hold interval. Apart from the alarm, a latch cuts fuel-pump power unless the driver completes a hidden switch-plus-brake gesture with the ignition on. Every interval may be programmed to zero and the sequence stays correct.

Top module: `car_alarm_ctrl`

## Requirements
- R1: After synchronous reset, and in the cycle after any cycle with `reprogram` high, the state is ARMED (`dbg_state` = 0). Normal transitions out of ARMED follow from the next edge on.
- R2: In ARMED, ignition high goes to DISARMED (code 4). If the ignition is low, the driver door goes to COUNTDOWN (code 1) with interval code 01, and the passenger door alone goes to COUNTDOWN with interval code 10. When both doors open in the same cycle, the driver door wins.
- R3: On entry to each timed state (COUNTDOWN, ALARM_HOLD, ARM_WAIT), `tmr_start` is high for exactly the first cycle in that state, and `tmr_sel` carries the requested code in that cycle.
- R4: In COUNTDOWN, `tmr_expired` moves the block to ALARM (code 2) only from the third cycle in the state onward. The strobe cycle and the cycle after it ignore the flag.
- R5: ALARM stays while any door is open. When all doors are closed it goes to ALARM_HOLD (code 3) with interval code 11. A door reopening there returns to ALARM, and an accepted expiry returns to ARMED.
- R6: Ignition high in COUNTDOWN, ALARM or ALARM_HOLD goes to DISARMED on the next edge.
- R7: Arming path: DISARMED goes to IGN_OFF (code 5) when the ignition drops. IGN_OFF goes to EXIT_OPEN (code 6) only when the driver door opens; the passenger door alone is ignored. EXIT_OPEN waits until no door is open and then enters ARM_WAIT (code 7) with interval code 00. An accepted expiry in ARM_WAIT goes to ARMED. Ignition high in IGN_OFF, EXIT_OPEN or ARM_WAIT returns to DISARMED.
- R8: Any door opening in ARM_WAIT returns to EXIT_OPEN. The arming interval restarts with a new strobe once all doors are closed again.
- R9: In ARMED the status lamp is off on entry and toggles on each cycle with `sec_tick` high.
- R10: The status lamp is steadily on in COUNTDOWN, ALARM and ALARM_HOLD, and off in the four disarmed states. `siren_en` is high only in ALARM and ALARM_HOLD.
- R11: `fuel_en` is low whenever the ignition is low. It goes high the cycle after a cycle in which the ignition is high (and was already high the cycle before) with hidden switch and brake both high. It then stays high until the ignition drops.
- R12: An interval of zero seconds gives the shortest legal path. For example, a zero countdown reaches ALARM on the fourth edge after the door opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ignition | input | 1 | Ignition switch level |
| driver_door | input | 1 | Driver door open level |
| pass_door | input | 1 | Passenger door open level |
| hidden_sw | input | 1 | Concealed switch level |
| brake | input | 1 | Brake pedal pressed level |
| sec_tick | input | 1 | One-cycle pulse once per second |
| reprogram | input | 1 | Interval table rewritten strobe |
| tmr_expired | input | 1 | External countdown at zero |
| tmr_start | output | 1 | Load-and-start pulse to the timer |
| tmr_sel | output | 2 | Interval code: 00 arm, 01 driver, 10 passenger, 11 siren hold |
| status_led | output | 1 | Dash status lamp |
| siren_en | output | 1 | Siren enable |
| fuel_en | output | 1 | Fuel-pump power enable |
| dbg_state | output | 4 | Current state code |

## Verification
A wrong state shows on `dbg_state` one edge after the stimulus that caused it. A wrong choice of timed state shows the same cycle on the `tmr_sel` code that goes with the strobe. Acting on a stale expiry too early moves the siren or the armed state one or two cycles ahead of the tick count. The bench times every countdown to the exact edge, so it sees this at once. A broken lamp phase or fuel latch shows on the first tick or first gesture after it.

// File: rtl/car_alarm_pkg.sv
package car_alarm_pkg;

    localparam int STATE_W = 4;
    localparam int SEL_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_ARMED      = 4'd0,
        ST_COUNT      = 4'd1,
        ST_ALARM      = 4'd2,
        ST_ALARM_HOLD = 4'd3,
        ST_DISARMED   = 4'd4,
        ST_IGN_OFF    = 4'd5,
        ST_EXIT_OPEN  = 4'd6,
        ST_ARM_WAIT   = 4'd7
    } alarm_state_t;

    typedef enum logic [SEL_W-1:0] {
        IV_ARM       = 2'b00,
        IV_DRIVER    = 2'b01,
        IV_PASSENGER = 2'b10,
        IV_HOLD      = 2'b11
    } interval_t;

    typedef struct packed {
        logic ign;
        logic drv;
        logic pas;
        logic any_door;
    } sense_t;

    function automatic logic is_alert(alarm_state_t s);
        return (s == ST_COUNT) || (s == ST_ALARM) || (s == ST_ALARM_HOLD);
    endfunction

    function automatic logic is_sounding(alarm_state_t s);
        return (s == ST_ALARM) || (s == ST_ALARM_HOLD);
    endfunction

endpackage

// File: rtl/alarm_timer_req.sv
module alarm_timer_req
    import car_alarm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req,
    input  interval_t req_sel,
    input  logic      tmr_expired,
    output logic      tmr_start,
    output interval_t tmr_sel,
    output logic      expire_ok
);
    logic      start_q;
    logic      guard_q;
    interval_t sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= 1'b0;
            guard_q <= 1'b0;
            sel_q   <= IV_ARM;
        end else begin
            start_q <= req;
            guard_q <= start_q;
            if (req) sel_q <= req_sel;
        end
    end

    assign tmr_start = start_q;
    assign tmr_sel   = sel_q;
    assign expire_ok = tmr_expired && !start_q && !guard_q;

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_start |=> !tmr_start);

    // R4
    stale_expiry_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_start |=> !expire_ok);
endmodule

// File: rtl/alarm_seq_fsm.sv
module alarm_seq_fsm
    import car_alarm_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         reprogram,
    input  sense_t       sense,
    input  logic         expire_ok,
    output alarm_state_t state,
    output logic         req,
    output interval_t    req_sel
);
    alarm_state_t nxt;

    always_comb begin
        nxt     = state;
        req     = 1'b0;
        req_sel = IV_ARM;
        if (reprogram) begin
            nxt = ST_ARMED;
        end else begin
            case (state)
                ST_ARMED: begin
                    if (sense.ign) begin
                        nxt = ST_DISARMED;
                    end else if (sense.drv) begin
                        nxt = ST_COUNT; req = 1'b1; req_sel = IV_DRIVER;
                    end else if (sense.pas) begin
                        nxt = ST_COUNT; req = 1'b1; req_sel = IV_PASSENGER;
                    end
                end
                ST_COUNT: begin
                    if (sense.ign)      nxt = ST_DISARMED;
                    else if (expire_ok) nxt = ST_ALARM;
                end
                ST_ALARM: begin
                    if (sense.ign) begin
                        nxt = ST_DISARMED;
                    end else if (!sense.any_door) begin
                        nxt = ST_ALARM_HOLD; req = 1'b1; req_sel = IV_HOLD;
                    end
                end
                ST_ALARM_HOLD: begin
                    if (sense.ign)           nxt = ST_DISARMED;
                    else if (sense.any_door) nxt = ST_ALARM;
                    else if (expire_ok)      nxt = ST_ARMED;
                end
                ST_DISARMED: begin
                    if (!sense.ign) nxt = ST_IGN_OFF;
                end
                ST_IGN_OFF: begin
                    if (sense.ign)      nxt = ST_DISARMED;
                    else if (sense.drv) nxt = ST_EXIT_OPEN;
                end
                ST_EXIT_OPEN: begin
                    if (sense.ign) begin
                        nxt = ST_DISARMED;
                    end else if (!sense.any_door) begin
                        nxt = ST_ARM_WAIT; req = 1'b1; req_sel = IV_ARM;
                    end
                end
                ST_ARM_WAIT: begin
                    if (sense.ign)           nxt = ST_DISARMED;
                    else if (sense.any_door) nxt = ST_EXIT_OPEN;
                    else if (expire_ok)      nxt = ST_ARMED;
                end
                default: nxt = ST_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_ARMED;
        else     state <= nxt;
    end

    // R1
    reprogram_home_chk: assert property (@(posedge clk) disable iff (rst)
        reprogram |=> state == ST_ARMED);

    // R6
    ign_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (sense.ign && !reprogram && is_alert(state)) |=> state == ST_DISARMED);
endmodule

// File: rtl/alarm_indicator.sv
module alarm_indicator
    import car_alarm_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  alarm_state_t state,
    input  logic         sec_tick,
    output logic         status_led,
    output logic         siren_en
);
    logic blink_q;

    always_ff @(posedge clk) begin
        if (rst || state != ST_ARMED) blink_q <= 1'b0;
        else if (sec_tick)            blink_q <= ~blink_q;
    end

    assign status_led = (state == ST_ARMED) ? blink_q : is_alert(state);
    assign siren_en   = is_sounding(state);

    // R9
    blink_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && $past(state == ST_ARMED) && $past(sec_tick))
            |-> status_led != $past(status_led));
endmodule

// File: rtl/fuel_interlock.sv
module fuel_interlock (
    input  logic clk,
    input  logic rst,
    input  logic ignition,
    input  logic hidden_sw,
    input  logic brake,
    output logic fuel_en
);
    logic ign_d;
    logic fuel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ign_d  <= 1'b0;
            fuel_q <= 1'b0;
        end else begin
            ign_d <= ignition;
            if (!ignition)                                fuel_q <= 1'b0;
            else if (ign_d && hidden_sw && brake)         fuel_q <= 1'b1;
        end
    end

    assign fuel_en = fuel_q && ignition;

    // R11
    fuel_gesture_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(fuel_en) |-> $past(hidden_sw && brake && ignition));
endmodule

// File: rtl/car_alarm_ctrl.sv
module car_alarm_ctrl
    import car_alarm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ignition,
    input  logic               driver_door,
    input  logic               pass_door,
    input  logic               hidden_sw,
    input  logic               brake,
    input  logic               sec_tick,
    input  logic               reprogram,
    input  logic               tmr_expired,
    output logic               tmr_start,
    output logic [SEL_W-1:0]   tmr_sel,
    output logic               status_led,
    output logic               siren_en,
    output logic               fuel_en,
    output logic [STATE_W-1:0] dbg_state
);
    sense_t       sense;
    alarm_state_t state;
    logic         req;
    interval_t    req_sel;
    interval_t    sel_w;
    logic         expire_ok;

    assign sense = '{ign: ignition, drv: driver_door, pas: pass_door,
                     any_door: driver_door || pass_door};

    alarm_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .reprogram(reprogram), .sense(sense),
        .expire_ok(expire_ok), .state(state), .req(req), .req_sel(req_sel)
    );

    alarm_timer_req u_treq (
        .clk(clk), .rst(rst), .req(req), .req_sel(req_sel),
        .tmr_expired(tmr_expired), .tmr_start(tmr_start), .tmr_sel(sel_w),
        .expire_ok(expire_ok)
    );

    alarm_indicator u_ind (
        .clk(clk), .rst(rst), .state(state), .sec_tick(sec_tick),
        .status_led(status_led), .siren_en(siren_en)
    );

    fuel_interlock u_fuel (
        .clk(clk), .rst(rst), .ignition(ignition), .hidden_sw(hidden_sw),
        .brake(brake), .fuel_en(fuel_en)
    );

    assign tmr_sel   = sel_w;
    assign dbg_state = state;

    // R2
    driver_first_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ARMED && !reprogram && !ignition && driver_door)
            |=> (tmr_start && tmr_sel == IV_DRIVER));

    // R10
    alert_lamp_chk: assert property (@(posedge clk) disable iff (rst)
        siren_en |-> status_led);
endmodule

// File: tb/car_alarm_ctrl_bench.sv
module car_alarm_ctrl_bench;
    logic clk = 1'b0;
    logic rst, ignition, driver_door, pass_door, hidden_sw, brake;
    logic sec_tick, reprogram, tmr_expired;
    logic tmr_start, status_led, siren_en, fuel_en;
    logic [1:0] tmr_sel;
    logic [3:0] dbg_state;

    int checks = 0;
    int failures = 0;

    logic [3:0] iv [4];
    logic [3:0] tcnt;

    always #10 clk = ~clk;

    car_alarm_ctrl u_car_alarm_ctrl (
        .clk(clk), .rst(rst), .ignition(ignition), .driver_door(driver_door),
        .pass_door(pass_door), .hidden_sw(hidden_sw), .brake(brake),
        .sec_tick(sec_tick), .reprogram(reprogram), .tmr_expired(tmr_expired),
        .tmr_start(tmr_start), .tmr_sel(tmr_sel), .status_led(status_led),
        .siren_en(siren_en), .fuel_en(fuel_en), .dbg_state(dbg_state)
    );

    // external countdown model
    always @(posedge clk) begin
        if (rst)                        tcnt <= 4'd0;
        else if (tmr_start)             tcnt <= iv[tmr_sel];
        else if (sec_tick && tcnt != 0) tcnt <= tcnt - 4'd1;
    end
    assign tmr_expired = (tcnt == 4'd0);

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic tick();
        sec_tick = 1'b1;
        step();
        sec_tick = 1'b0;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_iv(input int v);
        for (int i = 0; i < 4; i++) iv[i] = 4'(v);
    endtask

    task automatic go_armed();
        ignition = 0; driver_door = 0; pass_door = 0;
        reprogram = 1; step(); reprogram = 0;
    endtask

    initial begin
        #(20ns * 150000);
        failures++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1; ignition = 0; driver_door = 0; pass_door = 0;
        hidden_sw = 0; brake = 0; sec_tick = 0; reprogram = 0;
        set_iv(0);
        step(); step();
        rst = 0;
        // R1 reset state
        chk("R1 reset state", dbg_state, 0);
        chk("R1 reset start", tmr_start, 0);
        chk("R10 reset siren", siren_en, 0);
        chk("R11 reset fuel", fuel_en, 0);
        // R9 blink
        chk("R9 lamp entry", status_led, 0);
        tick(); chk("R9 lamp tick1", status_led, 1);
        step(); chk("R9 lamp hold", status_led, 1);
        tick(); chk("R9 lamp tick2", status_led, 0);

        // R2 R4 R5 R12 countdown and hold timing sweep
        for (int d = 0; d < 2; d++) begin
            for (int l = 0; l < 4; l++) begin
                set_iv(l);
                go_armed();
                if (d == 0) driver_door = 1; else pass_door = 1;
                step();
                chk("R2 countdown state", dbg_state, 1);
                chk("R3 countdown strobe", tmr_start, 1);
                chk("R2 countdown sel", tmr_sel, d == 0 ? 1 : 2);
                chk("R10 lamp countdown", status_led, 1);
                driver_door = 0; pass_door = 0;
                step();
                chk("R3 strobe single", tmr_start, 0);
                step();
                for (int k = 0; k < l; k++) begin
                    chk("R4 no early siren", siren_en, 0);
                    tick();
                end
                chk("R4 expiry not yet acted", dbg_state, 1);
                driver_door = 1;
                step();
                chk("R12 siren on time", dbg_state, 2);
                chk("R10 siren en", siren_en, 1);
                step();
                chk("R5 siren held while open", dbg_state, 2);
                driver_door = 0;
                step();
                chk("R5 hold state", dbg_state, 3);
                chk("R5 hold strobe", tmr_start, 1);
                chk("R5 hold sel", tmr_sel, 3);
                step(); step();
                for (int k = 0; k < l; k++) begin
                    chk("R5 still holding", dbg_state, 3);
                    tick();
                end
                chk("R5 hold before act", siren_en, 1);
                step();
                chk("R5 back armed", dbg_state, 0);
                chk("R9 lamp off on rearm", status_led, 0);
            end
        end

        // R5 reopen during hold
        set_iv(3);
        go_armed();
        driver_door = 1; step(); step(); step(); tick(); tick(); tick(); step();
        chk("R5 alarm reached", dbg_state, 2);
        driver_door = 0; step();
        chk("R5 hold entry", dbg_state, 3);
        pass_door = 1; step();
        chk("R5 reopen to alarm", dbg_state, 2);
        pass_door = 0;

        // R2 tie
        go_armed();
        driver_door = 1; pass_door = 1; step();
        chk("R2 tie driver sel", tmr_sel, 1);
        driver_door = 0; pass_door = 0;

        // R1 reprogram from alarm, then re-trigger next edge
        set_iv(0);
        go_armed();
        driver_door = 1; step(); step(); step(); step();
        chk("R1 pre alarm", dbg_state, 2);
        reprogram = 1; step(); reprogram = 0;
        chk("R1 reprogram home", dbg_state, 0);
        chk("R1 siren cleared", siren_en, 0);
        step();
        chk("R1 normal after home", dbg_state, 1);
        driver_door = 0;

        // R6 ignition in each alert state
        for (int t = 1; t < 4; t++) begin
            set_iv(0);
            go_armed();
            driver_door = 1; step();
            if (t >= 2) begin step(); step(); step(); end
            if (t == 3) begin driver_door = 0; step(); end
            chk("R6 in alert state", dbg_state, t);
            ignition = 1; step();
            chk("R6 ignition disarm", dbg_state, 4);
            chk("R10 lamp disarmed", status_led, 0);
            driver_door = 0;
        end

        // R2 ignition in armed
        go_armed();
        ignition = 1; step();
        chk("R2 armed ignition", dbg_state, 4);

        // R7 R8 R12 arming sweep
        for (int l = 0; l < 4; l++) begin
            set_iv(l);
            go_armed();
            ignition = 1; step();
            chk("R7 disarmed", dbg_state, 4);
            ignition = 0; step();
            chk("R7 ign off", dbg_state, 5);
            pass_door = 1; step();
            chk("R7 passenger ignored", dbg_state, 5);
            pass_door = 0; driver_door = 1; step();
            chk("R7 exit open", dbg_state, 6);
            pass_door = 1; driver_door = 0; step();
            chk("R7 wait all closed", dbg_state, 6);
            pass_door = 0; step();
            chk("R7 arm wait", dbg_state, 7);
            chk("R3 arm strobe", tmr_start, 1);
            chk("R7 arm sel", tmr_sel, 0);
            step(); step();
            if (l == 2) begin
                tick();
                pass_door = 1; step();
                chk("R8 reopen", dbg_state, 6);
                pass_door = 0; step();
                chk("R8 restart", dbg_state, 7);
                chk("R8 restart strobe", tmr_start, 1);
                step(); step();
            end
            for (int k = 0; k < l; k++) begin
                chk("R7 still waiting", dbg_state, 7);
                tick();
            end
            chk("R7 before act", dbg_state, 7);
            step();
            chk("R7 armed", dbg_state, 0);
        end

        // R7 ignition during arm wait
        set_iv(5);
        go_armed();
        ignition = 1; step(); ignition = 0; step();
        driver_door = 1; step(); driver_door = 0; step();
        ignition = 1; step();
        chk("R7 ignition in arm wait", dbg_state, 4);

        // R11 fuel interlock
        ignition = 0; hidden_sw = 1; brake = 1; step(); step();
        chk("R11 no fuel ign off", fuel_en, 0);
        hidden_sw = 0; brake = 0; ignition = 1; step(); step();
        hidden_sw = 1; step();
        chk("R11 hidden only", fuel_en, 0);
        hidden_sw = 0; brake = 1; step();
        chk("R11 brake only", fuel_en, 0);
        hidden_sw = 1; step();
        chk("R11 gesture latches", fuel_en, 1);
        hidden_sw = 0; brake = 0; step(); step();
        chk("R11 stays latched", fuel_en, 1);
        ignition = 0; #1;
        chk("R11 ign off cuts", fuel_en, 0);
        step(); ignition = 1; step(); step();
        chk("R11 not relatched", fuel_en, 0);
        ignition = 0; step();
        hidden_sw = 1; brake = 1; ignition = 1; step();
        chk("R11 needs prior ignition", fuel_en, 0);
        step();
        chk("R11 latch after settle", fuel_en, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule